// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter

A small binary counter stage whose clear, parallel load and count are all decided at the rising clock edge. Clear outranks load, and load outranks count. Counting needs two enables. The first, `en_p`, only gates the count. The second, `en_t`, gates both the count and the carry output. Because of this split, stages can be chained: a lower stage's carry drives the next stage's `en_t`, while all stages share `en_p`.

A build parameter chooses the counting sequence. `SEQ_FULL` wraps through all 2^WIDTH states. `SEQ_CARRY_RELOAD` uses the carry as an internal load request, so the counter restarts at a programmable start value after the all-ones state. `SEQ_TERM_CLEAR` ANDs only the state bits that are 1 in a programmable terminal value. That partial decode acts as an internal clear, so the counter restarts at zero after the terminal state.

The counter has no asynchronous path. It powers up unknown, and its user must apply one clear edge before relying on it. No data stream passes through the block, so there is no handshake; every pin is a plain control or status pin.

Top module: `sync_preset_counter`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, `q` becomes 0 on that edge, whatever `ld_n`, `en_p` and `en_t` are.
- R2: When `clr_n` is 1 and `ld_n` is 0 at an edge, `q` takes the value of `din` on that edge, whatever the enables are.
- R3: With `clr_n`=1, `ld_n`=1 and no internal restart, `q` increments by one per edge only when `en_p` and `en_t` are both 1. If either enable is 0, `q` holds.
- R4: `carry` is 1 exactly when every bit of `q` is 1 and `en_t` is 1. The value of `en_p` has no effect on it.
- R5: In `SEQ_FULL` with both enables held at 1, the count wraps from all-ones to 0. Bit k of `q` therefore toggles every 2^k edges, giving divide-by-2, 4, 8 and 16 outputs on bits 0 to 3.
- R6: In `SEQ_CARRY_RELOAD`, an edge with `carry`=1, `clr_n`=1 and `ld_n`=1 loads `START_VAL` (default 5), even when `en_p` is 0. An external load (`ld_n`=0) takes precedence over this reload. Running free from any state at or above 5, the counter repeats the 11 states 5 to 15.
- R7: In `SEQ_TERM_CLEAR`, an edge at which every bit that is 1 in `TERM_STATE` is also 1 in `q` clears `q` to 0. With the default of 10, this tests bits 3 and 1. The clear happens whatever `ld_n` and the enables are. Running free from 0, the counter repeats the 11 states 0 to 10.
- R8: Two `SEQ_FULL` stages form an 8-bit counter when the lower stage's `carry` drives the upper stage's `en_t` and both stages share `en_p` and the clock. The pair then counts 0 to 255 and wraps.
- R9: `clr_n` and `ld_n` act only at the rising edge. A pulse on either one that starts and ends between two edges leaves `q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel load, active low |
| din | input | WIDTH | Parallel load value |
| en_p | input | 1 | Count enable that does not affect the carry |
| en_t | input | 1 | Count enable that also qualifies the carry |
| q | output | WIDTH | Current count |
| carry | output | 1 | All-ones state with `en_t` high |

## Verification
The bench builds five instances at WIDTH 4. A `SEQ_FULL` instance checks priority, the enables, the carry and the divide-by outputs. A `SEQ_CARRY_RELOAD` instance with start value 5 shows the 5-to-15 loop and the reload happening while `en_p` is low. A `SEQ_TERM_CLEAR` instance with terminal value 10 shows the 0-to-10 loop and the decoder clear overriding an external load. Two chained `SEQ_FULL` instances run a full 8-bit turn of 256 states, which exercises the carry hand-off across the chain at every upper-stage step.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    SEQ_FULL         = 2'd0,
    SEQ_CARRY_RELOAD = 2'd1,
    SEQ_TERM_CLEAR   = 2'd2
  } seq_mode_e;
endpackage

// File: rtl/cnt_carry_gen.sv
module cnt_carry_gen #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_t,
  output logic             carry
);
  // Carry looks only at the full state and the carry-qualifying enable.
  assign carry = en_t & (&q);
endmodule

// File: rtl/cnt_seq_ctrl.sv
module cnt_seq_ctrl #(
  parameter int                WIDTH      = 4,
  parameter cnt_pkg::seq_mode_e MODE      = cnt_pkg::SEQ_FULL,
  parameter int                START_VAL  = 5,
  parameter int                TERM_STATE = 10
) (
  input  logic [WIDTH-1:0] q,
  input  logic             carry,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic [WIDTH-1:0] din,
  output logic             clr_req,
  output logic             ld_req,
  output logic [WIDTH-1:0] ld_val
);
  localparam logic [WIDTH-1:0] START_W = WIDTH'(START_VAL);
  localparam logic [WIDTH-1:0] TERM_W  = WIDTH'(TERM_STATE);

  logic term_hit;
  logic reload_hit;

  generate
    if (MODE == cnt_pkg::SEQ_TERM_CLEAR) begin : g_term
      // Partial decode: only bits that are 1 in the terminal value take part.
      assign term_hit   = &(q | ~TERM_W);
      assign reload_hit = 1'b0;
    end else if (MODE == cnt_pkg::SEQ_CARRY_RELOAD) begin : g_reload
      assign term_hit   = 1'b0;
      assign reload_hit = carry;
    end else begin : g_full
      assign term_hit   = 1'b0;
      assign reload_hit = 1'b0;
    end
  endgenerate

  assign clr_req = ~clr_n | term_hit;
  assign ld_req  = ~ld_n | reload_hit;
  assign ld_val  = ~ld_n ? din : START_W;
endmodule

// File: rtl/cnt_bit_slice.sv
module cnt_bit_slice #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_req,
  input  logic             ld_req,
  input  logic [WIDTH-1:0] ld_val,
  input  logic             step,
  output logic [WIDTH-1:0] q
);
  // ones_below[k] is high when counting is enabled and bits 0..k-1 are all 1.
  logic [WIDTH:0] ones_below;
  assign ones_below[0] = step;

  generate
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
      assign ones_below[gi+1] = ones_below[gi] & q[gi];

      always_ff @(posedge clk) begin
        if (clr_req)     q[gi] <= 1'b0;
        else if (ld_req) q[gi] <= ld_val[gi];
        else             q[gi] <= q[gi] ^ ones_below[gi];
      end
    end
  endgenerate
endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter #(
  parameter int                WIDTH      = 4,
  parameter cnt_pkg::seq_mode_e MODE      = cnt_pkg::SEQ_FULL,
  parameter int                START_VAL  = 5,
  parameter int                TERM_STATE = 10
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] q,
  output logic             carry
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] START_W  = WIDTH'(START_VAL);
  localparam logic [WIDTH-1:0] TERM_W   = WIDTH'(TERM_STATE);

  logic             clr_req;
  logic             ld_req;
  logic [WIDTH-1:0] ld_val;
  logic             step;

  assign step = en_p & en_t;

  cnt_carry_gen #(.WIDTH(WIDTH)) u_carry (
    .q(q), .en_t(en_t), .carry(carry)
  );

  cnt_seq_ctrl #(
    .WIDTH(WIDTH), .MODE(MODE), .START_VAL(START_VAL), .TERM_STATE(TERM_STATE)
  ) u_ctrl (
    .q(q), .carry(carry), .clr_n(clr_n), .ld_n(ld_n), .din(din),
    .clr_req(clr_req), .ld_req(ld_req), .ld_val(ld_val)
  );

  cnt_bit_slice #(.WIDTH(WIDTH)) u_bits (
    .clk(clk), .clr_req(clr_req), .ld_req(ld_req), .ld_val(ld_val),
    .step(step), .q(q)
  );

  // Checks are armed once the first clear edge has been seen.
  logic armed_q;
  always_ff @(posedge clk) armed_q <= armed_q | ~clr_n;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    !clr_n |=> q == '0); // R1
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    (clr_n && !ld_n && !clr_req) |=> q == $past(din)); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    (!clr_req && !ld_req && en_p && en_t) |=> q == WIDTH'($past(q) + 1'b1)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    (!clr_req && !ld_req && !(en_p && en_t)) |=> $stable(q)); // R3
  AST_CARRY_NEEDS_ENT: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
    carry |-> (en_t && q == ALL_ONES)); // R4

  generate
    if (MODE == cnt_pkg::SEQ_FULL) begin : g_chk_full
      AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        (clr_n && ld_n && carry && en_p) |=> q == '0); // R5
    end else if (MODE == cnt_pkg::SEQ_CARRY_RELOAD) begin : g_chk_reload
      AST_RELOAD_START: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        (clr_n && ld_n && carry) |=> q == START_W); // R6
    end else begin : g_chk_term
      AST_TERM_CLEARS: assert property (@(posedge clk) disable iff (armed_q !== 1'b1)
        (q == TERM_W) |=> q == '0); // R7
    end
  endgenerate
endmodule

// File: tb/sync_preset_counter_tb.sv
module sync_preset_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic         ld_n = 1'b1;
  logic [W-1:0] din = '0;
  logic         en_p = 1'b0;
  logic         en_t = 1'b0;

  logic [W-1:0] q_f, q_r, q_c, q_lo, q_hi;
  logic         c_f, c_r, c_c, c_lo, c_hi;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_preset_counter #(.WIDTH(W), .MODE(cnt_pkg::SEQ_FULL)) u_dut (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din), .en_p(en_p), .en_t(en_t),
    .q(q_f), .carry(c_f));
  sync_preset_counter #(.WIDTH(W), .MODE(cnt_pkg::SEQ_CARRY_RELOAD), .START_VAL(5)) u_rl (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din), .en_p(en_p), .en_t(en_t),
    .q(q_r), .carry(c_r));
  sync_preset_counter #(.WIDTH(W), .MODE(cnt_pkg::SEQ_TERM_CLEAR), .TERM_STATE(10)) u_tc (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din), .en_p(en_p), .en_t(en_t),
    .q(q_c), .carry(c_c));
  sync_preset_counter #(.WIDTH(W), .MODE(cnt_pkg::SEQ_FULL)) u_cas_lo (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din), .en_p(en_p), .en_t(en_t),
    .q(q_lo), .carry(c_lo));
  sync_preset_counter #(.WIDTH(W), .MODE(cnt_pkg::SEQ_FULL)) u_cas_hi (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din), .en_p(en_p), .en_t(c_lo),
    .q(q_hi), .carry(c_hi));

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_clear();
    clr_n = 1'b0; ld_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
    tick();
    clr_n = 1'b1;
  endtask

  task automatic do_load(input logic [W-1:0] v);
    ld_n = 1'b0; din = v;
    tick();
    ld_n = 1'b1;
  endtask

  task automatic t_reset();
    clr_n = 1'b0; ld_n = 1'b0; din = 4'd9; en_p = 1'b1; en_t = 1'b1;
    tick(); tick();
    check("R1 clear beats load/enables u_dut", q_f, 0);
    check("R1 clear u_rl", q_r, 0);
    check("R1 clear u_tc", q_c, 0);
    check("R1 clear cascade", {q_hi, q_lo}, 0);
    clr_n = 1'b1; ld_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
  endtask

  task automatic t_load();
    do_clear();
    en_p = 1'b0; en_t = 1'b0;
    do_load(4'd9);
    check("R2 load with enables off", q_f, 9);
    en_p = 1'b1; en_t = 1'b1;
    do_load(4'd3);
    check("R2 load beats count", q_f, 3);
  endtask

  task automatic t_enables();
    do_clear();
    do_load(4'd6);
    en_p = 1'b1; en_t = 1'b0; tick();
    check("R3 hold en_t low", q_f, 6);
    en_p = 1'b0; en_t = 1'b1; tick();
    check("R3 hold en_p low", q_f, 6);
    en_p = 1'b1; en_t = 1'b1; tick();
    check("R3 step both high", q_f, 7);
    en_p = 1'b0; en_t = 1'b0;
  endtask

  task automatic t_carry();
    do_clear();
    do_load(4'd15);
    en_p = 1'b0; en_t = 1'b1; #1;
    check("R4 carry at 15 with en_p low", c_f, 1);
    en_t = 1'b0; #1;
    check("R4 carry needs en_t", c_f, 0);
    do_load(4'd14);
    en_t = 1'b1; en_p = 1'b1; #1;
    check("R4 no carry at 14", c_f, 0);
    en_p = 1'b0; en_t = 1'b0;
  endtask

  task automatic t_free_run();
    int exp;
    do_clear();
    en_p = 1'b1; en_t = 1'b1;
    exp = 0;
    for (int i = 0; i < 34; i++) begin
      tick();
      exp = (exp + 1) % 16;
      check("R5 free-run divider bits", q_f, exp);
    end
    en_p = 1'b0; en_t = 1'b0;
  endtask

  task automatic t_reload();
    int exp;
    do_clear();
    do_load(4'd13);
    en_p = 1'b1; en_t = 1'b1;
    exp = 13;
    for (int i = 0; i < 24; i++) begin
      tick();
      exp = (exp == 15) ? 5 : exp + 1;
      check("R6 reload sequence 5..15", q_r, exp);
    end
    do_load(4'd15);
    en_p = 1'b0; en_t = 1'b1;
    tick();
    check("R6 reload with en_p low", q_r, 5);
    do_load(4'd15);
    do_load(4'd2);
    check("R6 external load beats reload", q_r, 2);
    en_t = 1'b0;
  endtask

  task automatic t_term();
    int exp;
    do_clear();
    en_p = 1'b1; en_t = 1'b1;
    exp = 0;
    for (int i = 0; i < 25; i++) begin
      tick();
      exp = (exp == 10) ? 0 : exp + 1;
      check("R7 term-clear sequence 0..10", q_c, exp);
    end
    en_p = 1'b0; en_t = 1'b0;
    do_load(4'd10);
    check("R7 load 10", q_c, 10);
    ld_n = 1'b0; din = 4'd7;
    tick();
    ld_n = 1'b1;
    check("R7 decoder clear beats load", q_c, 0);
  endtask

  task automatic t_cascade();
    int exp;
    do_clear();
    en_p = 1'b1; en_t = 1'b1;
    exp = 0;
    for (int i = 0; i < 260; i++) begin
      tick();
      exp = (exp + 1) % 256;
      check("R8 8-bit cascade", {q_hi, q_lo}, exp);
    end
    en_p = 1'b0; en_t = 1'b0;
  endtask

  task automatic t_edge_only();
    do_clear();
    do_load(4'd4);
    #2 clr_n = 1'b0;
    #2 clr_n = 1'b1;
    #1 check("R9 clear pulse between edges", q_f, 4);
    ld_n = 1'b0; din = 4'd12;
    #1 ld_n = 1'b1;
    en_p = 1'b1; en_t = 1'b1;
    tick();
    check("R9 no late clear/load effect", q_f, 5);
    en_p = 1'b0; en_t = 1'b0;
  endtask

  initial begin
    #1;
    t_reset();
    t_load();
    t_enables();
    t_carry();
    t_free_run();
    t_reload();
    t_term();
    t_cascade();
    t_edge_only();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule